// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the control logic of a byte-wide parallel flash. An asynchronous chip-select / output-enable / write-enable bus is oversampled by a fast system clock. The bus strobes are synchronized, and pulses that are too short are discarded. Each qualified write cycle goes to a sequencer. The sequencer accepts the protected unlock sequences for byte program, 128-byte sector erase, whole-array erase, and entering or leaving the identification mode.

An accepted program or erase starts an internal operation that lasts a parameterized number of clock cycles. While it runs, reads return status instead of stored data. Bit 7 is the complement of the byte being programmed, or 0 during an erase. Bit 6 flips on every completed read. Writes that arrive while the operation runs are discarded.

The array is a small behavioural RAM that powers up erased (all FFH). The tri-state data bus is represented by a separate output value `dqOut` and an output-enable flag `dqOe`.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write cycle is taken only while chip-select and write-enable are both low. Its address is the one present when the second of the two goes low, and its data is the one present just before the first of them rises.
- R2: Programming needs three unlock writes and then one address/data write: AAH to 555H, then 55H to 2AAH, then A0H to 555H. Addresses are compared on the ADDR_W low bits. The programmed byte becomes its old value ANDed with the written data.
- R3: Sector erase needs six writes: AAH@555H, 55H@2AAH, 80H@555H, AAH@555H, 55H@2AAH, then 20H at any address in the sector. The sector is selected by address bits above bit 6. All 128 bytes of that sector become FFH, and no other byte changes.
- R4: The same sequence ending in 10H at 555H sets every byte of the array to FFH.
- R5: A write that does not match the next expected step returns the sequencer to read mode. A later lone address/data write then changes nothing.
- R6: Every write that arrives while an internal operation runs is discarded, including unlock bytes.
- R7: While busy, read bit 7 is the complement of bit 7 of the programmed data, or 0 during an erase. After completion, reads return true array data.
- R8: While busy, read bit 6 inverts on each successive read. After completion, two reads of the same address return the same value.
- R9: AAH@555H, 55H@2AAH, 90H@555H enters identification mode, in which address 0 reads BFH and address 1 reads DEV_ID. A write of F0H leaves the mode, but is discarded while an operation runs.
- R10: dqOe is high only while chip-select and output-enable are both low. dqOut is 00H whenever dqOe is low.
- R11: A write pulse shorter than GLITCH_MIN clock cycles is rejected, and a pulse of exactly GLITCH_MIN cycles is accepted. A write pulse during which output-enable is low is also rejected.
- R12: After reset the sequencer is idle, not busy, not in identification mode, and reads return the erased array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| dqIn | input | 8 | Data written by the host |
| dqOut | output | 8 | Data presented on reads |
| dqOe | output | 1 | High when the data bus is driven |

## Verification
The bench uses the default parameters. ADDR_W=11 gives a 2 KiB array of sixteen sectors, small enough to shadow completely in the bench. PROG_CYC=40 keeps a program short, yet leaves time for two status reads and one discarded write inside the busy window. With SECT_CYC=200, the sector timer outlasts its 128-byte walk, while the 2048-byte walk of a whole-array erase outlasts CHIP_CYC=64. GLITCH_MIN=3 allows both a rejected 1-cycle pulse and an accepted 3-cycle pulse.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_U1, SEQ_U2, SEQ_PROG, SEQ_E3, SEQ_E4, SEQ_E5, SEQ_BUSY
  } seqState_t;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} opKind_t;

  typedef struct packed {
    logic busy;
    logic busyErase;
    logic idMode;
    logic progCommit;
    logic eraseEn;
  } ctrlStrobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OPC_PROG   = 8'hA0;
  localparam logic [7:0] OPC_ERASE  = 8'h80;
  localparam logic [7:0] OPC_ID_ON  = 8'h90;
  localparam logic [7:0] OPC_ID_OFF = 8'hF0;
  localparam logic [7:0] OPC_CHIP   = 8'h10;
  localparam logic [7:0] OPC_SECT   = 8'h20;
  localparam logic [7:0] MAKER_CODE = 8'hBF;
  localparam int         SECT_OFS_W = 7;

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int ADDR_W     = 11,
  parameter int GLITCH_MIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dqIn,
  output logic              wrEvt,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              rdDone
);
  localparam int CNT_W = $clog2(GLITCH_MIN + 1);

  logic [1:0]        ceSync, weSync, oeSync;
  logic [ADDR_W-1:0] addrP0, addrP1;
  logic [7:0]        dataP0, dataP1;
  logic              wrLowQ, rdLowQ, inhibit;
  logic [CNT_W-1:0]  lowCnt;
  logic              wrLow, rdLow;

  assign wrLow = ~ceSync[1] & ~weSync[1];
  assign rdLow = ~ceSync[1] & ~oeSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceSync  <= '1;
      weSync  <= '1;
      oeSync  <= '1;
      addrP0  <= '0;
      addrP1  <= '0;
      dataP0  <= '0;
      dataP1  <= '0;
      wrLowQ  <= 1'b0;
      rdLowQ  <= 1'b0;
      inhibit <= 1'b0;
      lowCnt  <= '0;
      wrEvt   <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      rdDone  <= 1'b0;
    end else begin
      ceSync <= {ceSync[0], ceN};
      weSync <= {weSync[0], weN};
      oeSync <= {oeSync[0], oeN};
      addrP0 <= addr;
      addrP1 <= addrP0;
      dataP0 <= dqIn;
      dataP1 <= dataP0;
      wrLowQ <= wrLow;
      rdLowQ <= rdLow;
      wrEvt  <= 1'b0;
      rdDone <= 1'b0;
      if (wrLow) begin
        if (!wrLowQ) begin
          wrAddr  <= addrP1;
          lowCnt  <= CNT_W'(1);
          inhibit <= ~oeSync[1];
        end else begin
          if (lowCnt < CNT_W'(GLITCH_MIN)) lowCnt <= lowCnt + CNT_W'(1);
          if (!oeSync[1]) inhibit <= 1'b1;
        end
        wrData <= dataP1;
      end else if (wrLowQ) begin
        wrEvt <= (lowCnt >= CNT_W'(GLITCH_MIN)) && !inhibit;
      end
      if (rdLowQ && !rdLow) rdDone <= 1'b1;
    end
  end

  // R1: one qualified write per strobe pulse
  p_single_event_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrEvt |=> !wrEvt);

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PROG_CYC = 40,
  parameter int SECT_CYC = 200,
  parameter int CHIP_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEvt,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output ctrlStrobe_t       stb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [ADDR_W-1:0] eraseAddr
);
  localparam int SECT_BYTES  = 1 << SECT_OFS_W;
  localparam int ARRAY_BYTES = 1 << ADDR_W;
  localparam int SEC_W       = ADDR_W - SECT_OFS_W;
  localparam int PROG_LEN    = (PROG_CYC > 1) ? PROG_CYC : 1;
  localparam int SECT_LEN    = (SECT_CYC > SECT_BYTES) ? SECT_CYC : SECT_BYTES;
  localparam int CHIP_LEN    = (CHIP_CYC > ARRAY_BYTES) ? CHIP_CYC : ARRAY_BYTES;
  localparam int MAX_LEN     = (PROG_LEN > SECT_LEN) ?
                               ((PROG_LEN > CHIP_LEN) ? PROG_LEN : CHIP_LEN) :
                               ((SECT_LEN > CHIP_LEN) ? SECT_LEN : CHIP_LEN);
  localparam int CNT_W       = $clog2(MAX_LEN + 1);
  localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(16'h2AAA);

  seqState_t         state;
  opKind_t           kind;
  logic [CNT_W-1:0]  opCnt, lenM1;
  logic [SEC_W-1:0]  sectBase;
  logic              idMode, hitA, hitB, opLast, inSpan;

  assign hitA = (wrAddr == KEY_ADDR_A);
  assign hitB = (wrAddr == KEY_ADDR_B);

  always_comb begin
    case (kind)
      OP_SECT: lenM1 = CNT_W'(SECT_LEN - 1);
      OP_CHIP: lenM1 = CNT_W'(CHIP_LEN - 1);
      default: lenM1 = CNT_W'(PROG_LEN - 1);
    endcase
  end

  assign opLast = (opCnt == lenM1);
  assign inSpan = (kind == OP_CHIP) ? (opCnt < CNT_W'(ARRAY_BYTES))
                                    : (opCnt < CNT_W'(SECT_BYTES));

  always_comb begin
    stb.busy       = (state == SEQ_BUSY);
    stb.busyErase  = stb.busy && (kind != OP_PROG);
    stb.idMode     = idMode;
    stb.progCommit = stb.busy && (kind == OP_PROG) && opLast;
    stb.eraseEn    = stb.busyErase && inSpan;
    if (kind == OP_CHIP) eraseAddr = opCnt[ADDR_W-1:0];
    else                 eraseAddr = {sectBase, opCnt[SECT_OFS_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      kind     <= OP_PROG;
      opCnt    <= '0;
      sectBase <= '0;
      idMode   <= 1'b0;
      opAddr   <= '0;
      opData   <= '0;
    end else if (state == SEQ_BUSY) begin
      if (opLast) begin
        state <= SEQ_IDLE;
        opCnt <= '0;
      end else begin
        opCnt <= opCnt + CNT_W'(1);
      end
    end else if (wrEvt) begin
      state <= SEQ_IDLE;
      case (state)
        SEQ_IDLE: begin
          if (hitA && wrData == KEY_FIRST) state <= SEQ_U1;
          else if (wrData == OPC_ID_OFF)   idMode <= 1'b0;
        end
        SEQ_U1: if (hitB && wrData == KEY_SECOND) state <= SEQ_U2;
        SEQ_U2: if (hitA) begin
          case (wrData)
            OPC_PROG:   state  <= SEQ_PROG;
            OPC_ERASE:  state  <= SEQ_E3;
            OPC_ID_ON:  idMode <= 1'b1;
            OPC_ID_OFF: idMode <= 1'b0;
            default:    state  <= SEQ_IDLE;
          endcase
        end
        SEQ_PROG: begin
          opAddr <= wrAddr;
          opData <= wrData;
          kind   <= OP_PROG;
          opCnt  <= '0;
          state  <= SEQ_BUSY;
        end
        SEQ_E3: if (hitA && wrData == KEY_FIRST)  state <= SEQ_E4;
        SEQ_E4: if (hitB && wrData == KEY_SECOND) state <= SEQ_E5;
        SEQ_E5: begin
          if (hitA && wrData == OPC_CHIP) begin
            kind  <= OP_CHIP;
            opCnt <= '0;
            state <= SEQ_BUSY;
          end else if (wrData == OPC_SECT) begin
            kind     <= OP_SECT;
            sectBase <= wrAddr[ADDR_W-1:SECT_OFS_W];
            opCnt    <= '0;
            state    <= SEQ_BUSY;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R6, R9: a write during an operation leaves the operation and mode untouched
  p_busy_ignores_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && wrEvt && !opLast) |=>
      (stb.busy && $stable(opAddr) && $stable(opData) && $stable(idMode)));

  // R2: the sequencer returns to read mode when the timer ends
  p_busy_ends_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && opLast) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [7:0]  DEV_ID = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdDone,
  output logic [7:0]        rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] arrByte, progOld;
  logic       toggleBit;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  assign progOld = mem[opAddr];
  assign arrByte = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (stb.progCommit)   mem[opAddr]    <= progOld & opData;
    else if (stb.eraseEn) mem[eraseAddr] <= 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      toggleBit <= 1'b0;
    else if (rdDone && stb.busy)    toggleBit <= ~toggleBit;
  end

  always_comb begin
    if (stb.busy)
      rdData = {(stb.busyErase ? 1'b0 : ~opData[7]), toggleBit, arrByte[5:0]};
    else if (stb.idMode)
      rdData = (rdAddr == '0) ? MAKER_CODE :
               (rdAddr == ADDR_W'(1)) ? DEV_ID : 8'h00;
    else
      rdData = arrByte;
  end

  // R2, R3: one array write per cycle
  p_one_writer_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.progCommit, stb.eraseEn}));

  // R3: an erase step leaves the addressed byte at FFH
  p_erase_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseEn |=> (mem[$past(eraseAddr)] == 8'hFF));

  // R2: programming only clears bits
  p_prog_and_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.progCommit |=> (mem[$past(opAddr)] == ($past(progOld) & $past(opData))));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         GLITCH_MIN = 3,
  parameter int         PROG_CYC   = 40,
  parameter int         SECT_CYC   = 200,
  parameter int         CHIP_CYC   = 64,
  parameter logic [7:0] DEV_ID     = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dqIn,
  output logic [7:0]        dqOut,
  output logic              dqOe
);
  ctrlStrobe_t       stb;
  logic              wrEvt, rdDone;
  logic [ADDR_W-1:0] wrAddr, opAddr, eraseAddr;
  logic [7:0]        wrData, opData, rdData;

  flash_bus_sync #(.ADDR_W(ADDR_W), .GLITCH_MIN(GLITCH_MIN)) u_sync (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .wrEvt(wrEvt), .wrAddr(wrAddr),
    .wrData(wrData), .rdDone(rdDone));

  flash_ctrl #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
               .CHIP_CYC(CHIP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEvt(wrEvt), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .opAddr(opAddr), .opData(opData), .eraseAddr(eraseAddr));

  flash_datapath #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opAddr(opAddr), .opData(opData),
    .eraseAddr(eraseAddr), .rdAddr(addr), .rdDone(rdDone), .rdData(rdData));

  assign dqOe  = ~ceN & ~oeN;
  assign dqOut = dqOe ? rdData : 8'h00;

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 11;
  localparam logic [AW-1:0] KA = 11'h555;
  localparam logic [AW-1:0] KB = 11'h2AA;
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {11'h010, 8'hF0}, {11'h010, 8'h3C}, {11'h17F, 8'h12}, {11'h180, 8'h00},
    {11'h1C3, 8'hA5}, {11'h1FF, 8'h7E}, {11'h200, 8'h81}, {11'h7FF, 8'hC3}};

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dqIn = '0, dqOut;
  logic dqOe;
  int nChecks = 0, nFail = 0;
  logic [7:0] model [1 << AW];

  always #4 clk = ~clk;

  flash_cmd_seq u0 (.clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
                    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input int lowCyc = 4, input bit oeLow = 1'b0);
    @(negedge clk);
    addr = a; dqIn = d; oeN = ~oeLow; ceN = 1'b0; weN = 1'b0;
    repeat (lowCyc) @(negedge clk);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #2;
    d = dqOut; oe = dqOe;
    @(negedge clk);
    oeN = 1'b1; ceN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0); wr(a, d);
  endtask

  task automatic eraseSeq(input logic [AW-1:0] a, input logic [7:0] opc);
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h80);
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(a, opc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic oe;
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state, R10 bus enable
    rd(11'h005, d, oe);
    chk("R12 erased after reset", d, 8'hFF);
    chk("R10 dqOe on read", {7'd0, oe}, 8'h01);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1;
    @(posedge clk); #2;
    chk("R10 dqOe off with oeN high", {7'd0, dqOe}, 8'h00);
    chk("R10 dqOut quiet", dqOut, 8'h00);
    @(negedge clk); ceN = 1'b1;

    // R2 table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [AW-1:0] a;
      logic [7:0] dv;
      a = VEC[v][18:8]; dv = VEC[v][7:0];
      prog(a, dv);
      model[a] = model[a] & dv;
      repeat (60) @(negedge clk);
      rd(a, d, oe);
      chk($sformatf("R2 program vector %0d", v), d, model[a]);
    end

    // R7, R8 status while programming
    prog(11'h100, 8'h5A);
    rd(11'h100, d, oe);
    rd(11'h100, d2, oe);
    chk("R7 DQ7 complement during program", {7'd0, d[7]}, 8'h01);
    chk("R8 DQ6 flips between reads", {7'd0, d[6] ^ d2[6]}, 8'h01);
    model[11'h100] = 8'h5A;
    repeat (60) @(negedge clk);
    rd(11'h100, d, oe);
    rd(11'h100, d2, oe);
    chk("R7 true data after program", d, 8'h5A);
    chk("R8 no toggle after completion", d2, d);

    // R6 unlock byte during busy is dropped
    prog(11'h101, 8'h00);
    wr(KA, 8'hAA);
    model[11'h101] = 8'h00;
    repeat (60) @(negedge clk);
    wr(KB, 8'h55); wr(KA, 8'hA0); wr(11'h103, 8'h00);
    repeat (60) @(negedge clk);
    rd(11'h103, d, oe);
    chk("R6 write during busy ignored", d, 8'hFF);
    rd(11'h101, d, oe);
    chk("R6 running program completed", d, 8'h00);

    // R5 aborts
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h33); wr(11'h104, 8'h00);
    repeat (60) @(negedge clk);
    rd(11'h104, d, oe);
    chk("R5 bad command byte aborts", d, 8'hFF);
    wr(KA, 8'hAA); wr(11'h123, 8'h55); wr(KA, 8'hA0); wr(11'h105, 8'h00);
    repeat (60) @(negedge clk);
    rd(11'h105, d, oe);
    chk("R5 bad unlock address aborts", d, 8'hFF);

    // R11 glitch and exact-minimum pulses
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0);
    wr(11'h106, 8'h00, 1);
    repeat (10) @(negedge clk);
    rd(11'h106, d, oe);
    chk("R11 short pulse rejected", d, 8'hFF);
    wr(11'h107, 8'h0F, 3);
    model[11'h107] = 8'h0F;
    repeat (60) @(negedge clk);
    rd(11'h107, d, oe);
    chk("R11 minimum pulse accepted", d, 8'h0F);
    // R11 output-enable low inhibits
    wr(KA, 8'hAA, 4, 1'b1); wr(KB, 8'h55); wr(KA, 8'hA0); wr(11'h108, 8'h00);
    repeat (60) @(negedge clk);
    rd(11'h108, d, oe);
    chk("R11 write with oe low inhibited", d, 8'hFF);

    // R1 address at start, data at end of the pulse
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0);
    @(negedge clk);
    addr = 11'h109; dqIn = 8'hFF; ceN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    addr = 11'h10A; dqIn = 8'h24;
    repeat (3) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (80) @(negedge clk);
    model[11'h109] = 8'h24;
    rd(11'h109, d, oe);
    chk("R1 latched address and late data", d, 8'h24);
    rd(11'h10A, d, oe);
    chk("R1 later address unused", d, 8'hFF);

    // R3 sector erase of sector 3, R7 erase status
    eraseSeq(11'h1A5, 8'h20);
    rd(11'h1A5, d, oe);
    chk("R7 DQ7 zero during erase", {7'd0, d[7]}, 8'h00);
    repeat (300) @(negedge clk);
    for (int i = 11'h180; i < 11'h200; i++) model[i] = 8'hFF;
    rd(11'h180, d, oe); chk("R3 sector first byte", d, 8'hFF);
    rd(11'h1C3, d, oe); chk("R3 sector middle byte", d, 8'hFF);
    rd(11'h1FF, d, oe); chk("R3 sector last byte", d, 8'hFF);
    rd(11'h17F, d, oe); chk("R3 previous sector kept", d, model[11'h17F]);
    rd(11'h200, d, oe); chk("R3 next sector kept", d, model[11'h200]);

    // R9 identification mode
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h90);
    rd(11'h000, d, oe); chk("R9 maker code", d, 8'hBF);
    rd(11'h001, d, oe); chk("R9 device code", d, 8'h13);
    prog(11'h300, 8'h00);
    wr(11'h000, 8'hF0);
    model[11'h300] = 8'h00;
    repeat (60) @(negedge clk);
    rd(11'h000, d, oe); chk("R9 exit ignored while busy", d, 8'hBF);
    wr(11'h000, 8'hF0);
    rd(11'h000, d, oe); chk("R9 exit returns array", d, model[0]);
    rd(11'h300, d, oe); chk("R9 program in id mode", d, 8'h00);

    // R4 chip erase
    eraseSeq(KA, 8'h10);
    repeat (2200) @(negedge clk);
    rd(11'h010, d, oe); chk("R4 chip erase low", d, 8'hFF);
    rd(11'h300, d, oe); chk("R4 chip erase mid", d, 8'hFF);
    rd(11'h7FF, d, oe); chk("R4 chip erase top", d, 8'hFF);

    summary();
    $finish;
  end
endmodule